// File: doc/BRIEF.md
# Luma Quarter-Sample Interpolator

This block produces one fractional-position luma sample per clock for motion compensation. Each input is a window of six neighbouring integer 8-bit reference samples taken along one row or one column, plus a two-bit fractional offset in quarter-sample steps. The wanted position always lies between the two middle samples of the window. The window may be horizontal or vertical. The block treats both the same way, because only one dimension is filtered.

The half-sample value between the two middle samples comes from a symmetric six-tap filter with taps 1, -5, 20, 20, -5, 1. The filtered value is rounded, divided by 32 and clipped to the pixel range. The quarter positions on either side of that half sample are the rounded-up average of the half sample and the nearer middle integer sample. Offset zero passes the left middle sample through unchanged.

The datapath is a three-stage pipeline with no stall. The block accepts a window on every cycle where both `in_valid` and `in_ready` are high. The result appears on `out_pix` with a one-cycle `out_valid` strobe exactly three cycles later.

Top module: `sp_luma_interp`

## Requirements
- R1: A window accepted at clock edge k (in_valid and in_ready both high) gives `out_valid` high with its result after edge k+3, and only then. Windows may be accepted back to back, one per cycle.
- R2: `in_ready` and `out_valid` are 0 while `rst` is high. `in_ready` becomes 1 at the first clock edge at which `rst` is low.
- R3: The window is split into six PIX_W-bit lanes. Lane 0 (bits [7:0] at default width) is the leftmost sample, called A here; the others follow as B, C, D, E and F, with lane 5 in bits [47:40]. The samples of interest are C (lane 2) and D (lane 3). With in_frac = 0, the output equals C unchanged.
- R4: With in_frac = 2, the output is the half sample H = clip((A - 5B + 20C + 20D - 5E + F + 16) >> 5), where the shift is arithmetic.
- R5: When the rounded and shifted sum of R4 is negative, H is 0.
- R6: When the rounded and shifted sum of R4 exceeds 2^PIX_W - 1, H is 2^PIX_W - 1.
- R7: With in_frac = 1, the output is (C + H + 1) >> 1.
- R8: With in_frac = 3, the output is (D + H + 1) >> 1.
- R9: A cycle with in_valid low produces no output. Idle gaps do not shift the latency or the results of the windows around them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window offered |
| in_ready | output | 1 | Block can take a window |
| in_win | input | 6*PIX_W | Six integer samples; lane 0 is the leftmost |
| in_frac | input | 2 | Quarter-sample offset: 0 integer, 1 left quarter, 2 half, 3 right quarter |
| out_valid | output | 1 | Result strobe, one cycle for each window |
| out_pix | output | PIX_W | Interpolated sample |

## Verification
The bench builds the block with the default PIX_W of 8, which gives a 15-bit signed accumulator. At that width, extreme 8-bit lanes push the filter sum below zero and above 255, so both clipping limits are reached. Directed windows with unequal lanes make the two quarter positions give different values. A long pseudo-random stream, with all four offsets and occasional idle cycles, checks that each result keeps its three-cycle slot.

// File: rtl/sp_interp_pkg.sv
package sp_interp_pkg;
  localparam int NUM_TAPS   = 6;
  localparam int NUM_PAIRS  = NUM_TAPS / 2;
  localparam int NORM_SHIFT = 5;
  localparam int ROUND_ADD  = 1 << (NORM_SHIFT - 1);
  localparam int CTR_LEFT   = 2;
  localparam int CTR_RIGHT  = 3;

  typedef enum logic [1:0] {
    FR_INT   = 2'd0,
    FR_QLEFT = 2'd1,
    FR_HALF  = 2'd2,
    FR_QRGHT = 2'd3
  } frac_e;

  // weight of the symmetric tap pair k (outer pair is k = 0)
  function automatic int pair_weight(input int k);
    case (k)
      0:       return 1;
      1:       return -5;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/sp_tap_sum.sv
module sp_tap_sum
  import sp_interp_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                               clk,
  input  logic                               en,
  input  logic [NUM_TAPS*PIX_W-1:0]          win,
  input  frac_e                              frac,
  output logic [NUM_PAIRS-1:0][PIX_W:0]      pair_q,
  output logic [PIX_W-1:0]                   left_q,
  output logic [PIX_W-1:0]                   right_q,
  output frac_e                              frac_q
);
  // fold the symmetric window: lane k with lane (NUM_TAPS-1-k)
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    always_ff @(posedge clk) begin
      if (en)
        pair_q[k] <= {1'b0, win[k*PIX_W +: PIX_W]}
                   + {1'b0, win[(NUM_TAPS-1-k)*PIX_W +: PIX_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      left_q  <= win[CTR_LEFT*PIX_W +: PIX_W];
      right_q <= win[CTR_RIGHT*PIX_W +: PIX_W];
      frac_q  <= frac;
    end
  end
endmodule

// File: rtl/sp_halfpel.sv
module sp_halfpel
  import sp_interp_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = PIX_W + 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [NUM_PAIRS-1:0][PIX_W:0] pair,
  input  logic [PIX_W-1:0]              left,
  input  logic [PIX_W-1:0]              right,
  input  frac_e                         frac,
  output logic [PIX_W-1:0]              half_q,
  output logic [PIX_W-1:0]              nb_q,
  output frac_e                         frac_q
);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] RND     = ACC_W'(ROUND_ADD);

  logic signed [ACC_W-1:0] prod [NUM_PAIRS];
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] scaled;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_mul
    assign prod[k] = ACC_W'(pair_weight(k)) * $signed(ACC_W'(pair[k]));
  end

  always_comb begin
    acc = RND;
    for (int k = 0; k < NUM_PAIRS; k++) acc = acc + prod[k];
    scaled = acc >>> NORM_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (scaled < 0)            half_q <= '0;
      else if (scaled > PIX_MAX) half_q <= PIX_MAX[PIX_W-1:0];
      else                       half_q <= scaled[PIX_W-1:0];
      nb_q   <= (frac == FR_QRGHT) ? right : left;
      frac_q <= frac;
    end
  end

  // R5: negative filter result floors at zero
  p_clip_low_r5: assert property (@(posedge clk) disable iff (rst)
    (en && scaled < 0) |=> half_q == '0);
  // R6: filter result above range saturates
  p_clip_high_r6: assert property (@(posedge clk) disable iff (rst)
    (en && scaled > PIX_MAX) |=> half_q == PIX_MAX[PIX_W-1:0]);
endmodule

// File: rtl/sp_qpel_sel.sv
module sp_qpel_sel
  import sp_interp_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PIX_W-1:0] half,
  input  logic [PIX_W-1:0] nb,
  input  frac_e            frac,
  output logic [PIX_W-1:0] pix_q
);
  logic [PIX_W:0]   avg_sum;
  logic [PIX_W-1:0] lo, hi;

  assign avg_sum = {1'b0, nb} + {1'b0, half} + {{PIX_W{1'b0}}, 1'b1};
  assign lo = (nb < half) ? nb : half;
  assign hi = (nb < half) ? half : nb;

  always_ff @(posedge clk) begin
    if (en) begin
      case (frac)
        FR_INT:  pix_q <= nb;
        FR_HALF: pix_q <= half;
        default: pix_q <= avg_sum[PIX_W:1];
      endcase
    end
  end

  // R3: integer offset passes the sample through
  p_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (en && frac == FR_INT) |=> pix_q == $past(nb));
  // R7 / R8: a quarter sample lies between its two neighbours
  p_avg_span_r7: assert property (@(posedge clk) disable iff (rst)
    (en && frac[0]) |=> (pix_q >= $past(lo)) && (pix_q <= $past(hi)));
endmodule

// File: rtl/sp_luma_interp.sv
module sp_luma_interp
  import sp_interp_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NUM_TAPS*PIX_W-1:0] in_win,
  input  logic [1:0]                in_frac,
  output logic                      out_valid,
  output logic [PIX_W-1:0]          out_pix
);
  localparam int ACC_W = PIX_W + 7;

  logic                          ready_q;
  logic                          accept;
  logic                          v1_q, v2_q, v3_q;
  logic [NUM_PAIRS-1:0][PIX_W:0] pair_s1;
  logic [PIX_W-1:0]              left_s1, right_s1;
  frac_e                         frac_s1, frac_s2;
  logic [PIX_W-1:0]              half_s2, nb_s2;

  assign accept = in_valid & ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      v3_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      v1_q    <= accept;
      v2_q    <= v1_q;
      v3_q    <= v2_q;
    end
  end

  sp_tap_sum #(.PIX_W(PIX_W)) u_taps (
    .clk    (clk),
    .en     (accept),
    .win    (in_win),
    .frac   (frac_e'(in_frac)),
    .pair_q (pair_s1),
    .left_q (left_s1),
    .right_q(right_s1),
    .frac_q (frac_s1)
  );

  sp_halfpel #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_half (
    .clk   (clk),
    .rst   (rst),
    .en    (v1_q),
    .pair  (pair_s1),
    .left  (left_s1),
    .right (right_s1),
    .frac  (frac_s1),
    .half_q(half_s2),
    .nb_q  (nb_s2),
    .frac_q(frac_s2)
  );

  sp_qpel_sel #(.PIX_W(PIX_W)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .en   (v2_q),
    .half (half_s2),
    .nb   (nb_s2),
    .frac (frac_s2),
    .pix_q(out_pix)
  );

  assign in_ready  = ready_q;
  assign out_valid = v3_q;

  // R1: one result strobe, exactly three edges after acceptance
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(accept, 3));
  // R2: reset closes the input side
  p_ready_rst_r2: assert property (@(posedge clk)
    rst |=> !in_ready && !out_valid);
endmodule

// File: tb/sim_sp_luma_interp.sv
module sim_sp_luma_interp;
  localparam int PW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [6*PW-1:0] in_win = '0;
  logic [1:0]      in_frac = '0;
  logic            out_valid;
  logic [PW-1:0]   out_pix;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int     exp_q   [$];
  int     stamp_q [$];
  string  tag_q   [$];
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sp_luma_interp #(.PIX_W(PW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_win(in_win), .in_frac(in_frac), .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic logic [6*PW-1:0] mk(int a, int b, int c, int d, int e, int f);
    return {PW'(f), PW'(e), PW'(d), PW'(c), PW'(b), PW'(a)};
  endfunction

  function automatic int model(logic [6*PW-1:0] w, int fr);
    int l [6];
    int s, h;
    for (int k = 0; k < 6; k++) l[k] = int'(w[k*PW +: PW]);
    s = l[0] - 5*l[1] + 20*l[2] + 20*l[3] - 5*l[4] + l[5];
    h = (s + 16) >>> 5;
    if (h < 0) h = 0;
    if (h > 255) h = 255;
    case (fr)
      0: return l[2];
      1: return (l[2] + h + 1) >> 1;
      2: return h;
      default: return (l[3] + h + 1) >> 1;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [6*PW-1:0] w, int fr, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_win   = w;
    in_frac  = fr[1:0];
    exp_q.push_back(model(w, fr));
    stamp_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected output", 1, 0);
      end else begin
        int e, st;
        string t;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        t  = tag_q.pop_front();
        check(t, int'(out_pix), e);
        check("R1 latency", cyc - st, 3);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    summary();
  end

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R2 in_ready in reset", int'(in_ready), 0);
    check("R2 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 in_ready after reset", int'(in_ready), 1);

    // directed corners
    send(mk(100,100,100,100,100,100), 2, "R4 flat half");
    send(mk(10,20,30,200,50,60), 0, "R3 integer pass");
    send(mk(10,20,30,200,50,60), 2, "R4 uneven half");
    send(mk(10,20,30,200,50,60), 1, "R7 left quarter");
    send(mk(10,20,30,200,50,60), 3, "R8 right quarter");
    send(mk(0,255,40,40,255,0), 2, "R5 clip low");
    send(mk(0,255,40,40,255,0), 1, "R5 R7 clip low quarter");
    send(mk(255,0,255,255,0,255), 2, "R6 clip high");
    send(mk(255,0,255,255,0,255), 3, "R6 R8 clip high quarter");
    idle(2);
    send(mk(1,2,3,4,5,6), 2, "R9 after gap");
    idle(1);
    send(mk(9,200,7,250,3,1), 3, "R9 after gap");
    send(mk(255,255,255,255,255,255), 0, "R3 max pass");
    send(mk(0,0,0,0,0,0), 1, "R7 zero");

    // pseudo-random stream with gaps
    for (int n = 0; n < 400; n++) begin
      logic [6*PW-1:0] w;
      int fr;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      w = {lfsr[15:0], lfsr[31:0]} ^ {16'h0, lfsr[7:0], lfsr[31:8]};
      fr = int'(lfsr[9:8]);
      case (fr)
        0: send(w, fr, "R3 random");
        1: send(w, fr, "R7 random");
        2: send(w, fr, "R4 random");
        default: send(w, fr, "R8 random");
      endcase
      if (lfsr[20:18] == 3'd0) idle(int'(lfsr[23:22]) + 1);
    end

    idle(6);
    check("R1 all results delivered", exp_q.size(), 0);
    check("R9 no output when idle", int'(out_valid), 0);
    summary();
  end
endmodule